// File: doc/BRIEF.md
# Single-Cycle 4-Bit Accumulator Processor

This block is a small stored-program processor. It holds a 4-bit program counter, a 4-bit accumulator, a zero flag, a halt flag and a data store of four 4-bit words. On every rising clock edge it executes one 7-bit instruction word. The instruction word is supplied combinationally by a program memory that sits outside the block. The block presents the program counter on an address output and reads the word back on an instruction input in the same cycle.

Arithmetic takes its second operand from the data store, not from the instruction. Opcode 000 halts the machine, so a program that runs into an empty (all-zero) word stops there. A halted machine ignores its instruction input and keeps all of its state until reset. The program counter, accumulator, zero flag, halt flag and all four data words are brought out for observation.

The reset input is asynchronous and active low. It takes effect at once, but its release passes through a two-stage synchronizer before execution starts.

Top module: `acc4_cpu`

## Requirements
- R1: While rst_n is low, pc_o, acc_o and all four words of ram_o read 0, halted_o reads 0 and zero_o reads 1.
- R2: After rst_n rises, the state stays at its reset value through the first two rising clock edges. The instruction at address 0 executes on the third rising edge.
- R3: The instruction word holds the opcode in bits [6:4] and the immediate in bits [3:0]. Opcode 001 loads the immediate into the accumulator. Every opcode other than 000, 100 and 101 sets PC to PC+1 modulo 16. imem_addr always equals pc_o.
- R4: Opcode 010 sets ACC to ACC + word, and opcode 011 sets ACC to ACC − word. "Word" is the data word selected by imm[1:0]. Both results wrap modulo 16, and subtraction is a two's-complement addition.
- R5: Opcode 110 loads the selected word into ACC. Opcode 111 writes ACC into the selected word on the executing edge, so the new value is visible on ram_o in the next cycle. imm[3:2] has no effect on which word is selected. Word i appears on ram_o[4i+3:4i].
- R6: Opcode 100 sets PC to the immediate. Opcode 101 sets PC to the immediate when ACC is 0 and to PC+1 otherwise.
- R7: Opcode 000 sets halted_o and leaves PC at the address of the halt word. From then on PC, ACC and RAM stay frozen, whatever is on imem_word, until reset.
- R8: zero_o is 1 exactly when acc_o is 0.
- R9: The Fibonacci program takes the pair (word0, word1) through the values (1,1), (1,2), (2,3), (3,5), (5,8), (8,D), (D,5), (5,2), (2,7), (7,9), each seen when PC reaches 3. It then jumps to the empty address 12 and halts there with PC = 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| imem_addr | output | 4 | Program memory address (current PC) |
| imem_word | input | 7 | Instruction word at imem_addr |
| pc_o | output | 4 | Program counter |
| acc_o | output | 4 | Accumulator |
| zero_o | output | 1 | High when the accumulator is zero |
| halted_o | output | 1 | High once a halt word has executed |
| ram_o | output | 16 | Data words; word i at bits [4i+3:4i] |

## Verification
Every instruction result (PC, ACC, a stored word, the halt flag) is due one rising edge after the edge on which its word is presented. The zero flag follows the accumulator in the same cycle. The bench therefore drives a model step at each rising edge and compares all outputs at the following falling edge. The only longer latency is the reset release: the first instruction takes effect on the third rising edge after rst_n rises. The bench counts those two idle edges before it starts stepping the model, and it checks that the reset state still holds at the falling edge after each of them.

// File: rtl/acc4_pkg.sv
package acc4_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_HALT = 3'b000,
    OP_LDI  = 3'b001,
    OP_ADD  = 3'b010,
    OP_SUB  = 3'b011,
    OP_JMP  = 3'b100,
    OP_JZ   = 3'b101,
    OP_LDA  = 3'b110,
    OP_STA  = 3'b111
  } opcode_e;

  typedef enum logic [1:0] {
    SRC_IMM = 2'd0,
    SRC_ADD = 2'd1,
    SRC_SUB = 2'd2,
    SRC_MEM = 2'd3
  } acc_src_e;

  typedef struct packed {
    logic     acc_we;
    acc_src_e src;
    logic     mem_we;
    logic     jmp;
    logic     jz;
    logic     hlt;
  } ctrl_t;
endpackage

// File: rtl/acc4_rst_sync.sv
module acc4_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/acc4_decode.sv
module acc4_decode
  import acc4_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output ctrl_t           ctrl
);
  always_comb begin
    ctrl = '{acc_we: 1'b0, src: SRC_IMM, mem_we: 1'b0,
             jmp: 1'b0, jz: 1'b0, hlt: 1'b0};
    case (opcode_e'(op))
      OP_HALT: ctrl.hlt = 1'b1;
      OP_LDI:  begin ctrl.acc_we = 1'b1; ctrl.src = SRC_IMM; end
      OP_ADD:  begin ctrl.acc_we = 1'b1; ctrl.src = SRC_ADD; end
      OP_SUB:  begin ctrl.acc_we = 1'b1; ctrl.src = SRC_SUB; end
      OP_JMP:  ctrl.jmp = 1'b1;
      OP_JZ:   ctrl.jz  = 1'b1;
      OP_LDA:  begin ctrl.acc_we = 1'b1; ctrl.src = SRC_MEM; end
      OP_STA:  ctrl.mem_we = 1'b1;
      default: ctrl.hlt = 1'b1;
    endcase
  end
endmodule

// File: rtl/acc4_dmem.sv
module acc4_dmem #(
  parameter int DW     = 4,
  parameter int DWORDS = 4,
  localparam int SELW  = $clog2(DWORDS)
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic [SELW-1:0]      addr,
  input  logic                 we,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic [DWORDS*DW-1:0] words_o
);
  logic [DW-1:0] words [DWORDS];

  for (genvar i = 0; i < DWORDS; i++) begin : g_word
    logic sel_en;
    assign sel_en = we && (addr == SELW'(i));

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)     words[i] <= '0;
      else if (sel_en) words[i] <= wdata;
    end

    assign words_o[i*DW +: DW] = words[i];
  end

  assign rdata = words[addr];

  // R5: a write is visible in the addressed word on the next cycle
  p_store_commit_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    we |=> words[$past(addr)] == $past(wdata));
endmodule

// File: rtl/acc4_cpu.sv
module acc4_cpu
  import acc4_pkg::*;
#(
  parameter int PCW    = 4,
  parameter int DW     = 4,
  parameter int DWORDS = 4,
  localparam int IW    = OP_W + PCW,
  localparam int SELW  = $clog2(DWORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [PCW-1:0]       imem_addr,
  input  logic [IW-1:0]        imem_word,
  output logic [PCW-1:0]       pc_o,
  output logic [DW-1:0]        acc_o,
  output logic                 zero_o,
  output logic                 halted_o,
  output logic [DWORDS*DW-1:0] ram_o
);
  logic           rst_int_n;
  logic [PCW-1:0] pc_q, pc_d;
  logic [DW-1:0]  acc_q, acc_d;
  logic           halted_q, halted_d;
  logic           run, acc_en, mem_en, jump_taken;
  logic [PCW-1:0] imm;
  logic [DW-1:0]  opnd;
  ctrl_t          ctrl;

  acc4_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

  acc4_decode u_dec (.op(imem_word[PCW +: OP_W]), .ctrl(ctrl));

  assign imm = imem_word[PCW-1:0];
  assign run = !halted_q;

  acc4_dmem #(.DW(DW), .DWORDS(DWORDS)) u_mem (
    .clk(clk), .rst_ni(rst_int_n), .addr(imm[SELW-1:0]),
    .we(mem_en), .wdata(acc_q), .rdata(opnd), .words_o(ram_o));

  // next-state logic
  always_comb begin
    jump_taken = ctrl.jmp || (ctrl.jz && (acc_q == '0));
    if (ctrl.hlt)        pc_d = pc_q;
    else if (jump_taken) pc_d = imm;
    else                 pc_d = pc_q + PCW'(1);

    case (ctrl.src)
      SRC_IMM: acc_d = DW'(imm);
      SRC_ADD: acc_d = acc_q + opnd;
      SRC_SUB: acc_d = acc_q + ~opnd + DW'(1);
      default: acc_d = opnd;
    endcase

    halted_d = ctrl.hlt;
    acc_en   = run && ctrl.acc_we;
    mem_en   = run && ctrl.mem_we;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
    end else if (run) begin
      pc_q     <= pc_d;
      halted_q <= halted_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign imem_addr = pc_q;
  assign pc_o      = pc_q;
  assign acc_o     = acc_q;
  assign zero_o    = (acc_q == '0);
  assign halted_o  = halted_q;

  // R3: immediate load lands in the accumulator
  p_ldi_load_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!halted_o && imem_word[PCW +: OP_W] == OP_LDI) |=> acc_o == DW'($past(imm)));

  // R3: sequential opcodes step PC by one
  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!halted_o && (imem_word[PCW +: OP_W] inside {OP_LDI, OP_ADD, OP_SUB, OP_LDA, OP_STA}))
    |=> pc_o == $past(pc_o) + PCW'(1));

  // R6: unconditional jump loads PC with the immediate
  p_jmp_target_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!halted_o && imem_word[PCW +: OP_W] == OP_JMP) |=> pc_o == $past(imm));

  // R7: a halted machine stays frozen
  p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    halted_o |=> halted_o && $stable(pc_o) && $stable(acc_o) && $stable(ram_o));

  // R7: a halt word sets the flag without moving PC
  p_halt_entry_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!halted_o && imem_word[PCW +: OP_W] == OP_HALT) |=> halted_o && $stable(pc_o));
endmodule

// File: tb/acc4_cpu_tb.sv
module acc4_cpu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  imem_addr;
  logic [6:0]  imem_word;
  logic [3:0]  pc_o, acc_o;
  logic        zero_o, halted_o;
  logic [15:0] ram_o;

  logic [6:0] prog [16];
  logic [3:0] m_pc, m_acc;
  logic [3:0] m_ram [4];
  logic       m_halt;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign imem_word = prog[imem_addr];

  acc4_cpu u_dut (.clk(clk), .rst_n(rst_n), .imem_addr(imem_addr),
    .imem_word(imem_word), .pc_o(pc_o), .acc_o(acc_o), .zero_o(zero_o),
    .halted_o(halted_o), .ram_o(ram_o));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] m_ram_flat();
    return {m_ram[3], m_ram[2], m_ram[1], m_ram[0]};
  endfunction

  task automatic cmp_all(input string req);
    check({req, " pc"},   pc_o, m_pc);
    check({req, " addr"}, imem_addr, m_pc);
    check({req, " acc"},  acc_o, m_acc);
    check({req, " ram"},  ram_o, m_ram_flat());
    check({req, " halt"}, halted_o, m_halt);
    check("R8 zero", zero_o, acc_o == 4'd0);
  endtask

  // reference step built from the opcode table
  task automatic model_step(input logic [6:0] w);
    logic [3:0] imm, nxt;
    logic [1:0] a;
    if (m_halt) return;
    imm = w[3:0]; a = imm[1:0]; nxt = m_pc + 4'd1;
    case (w[6:4])
      3'd0: begin m_halt = 1'b1; nxt = m_pc; end
      3'd1: m_acc = imm;
      3'd2: m_acc = m_acc + m_ram[a];
      3'd3: m_acc = m_acc - m_ram[a];
      3'd4: nxt = imm;
      3'd5: if (m_acc == 4'd0) nxt = imm;
      3'd6: m_acc = m_ram[a];
      default: m_ram[a] = m_acc;
    endcase
    m_pc = nxt;
  endtask

  task automatic run_cycles(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [6:0] w;
      w = prog[m_pc];
      @(posedge clk);
      model_step(w);
      @(negedge clk);
      cmp_all(req);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_pc = '0; m_acc = '0; m_halt = 1'b0;
    for (int i = 0; i < 4; i++) m_ram[i] = '0;
    @(negedge clk);
    cmp_all("R1");
    rst_n = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      cmp_all("R2 idle");
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) prog[i] = 7'h00;
  endtask

  int pairs_seen;
  logic [7:0] exp_pairs [10];

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    clear_prog();

    // R1/R2: reset value held, first word runs on third edge
    prog[0] = 7'h15;
    do_reset();
    run_cycles(1, "R2 first");
    check("R2 acc after first exec", acc_o, 5);
    check("R3 pc after LDI", pc_o, 1);

    // directed arithmetic, memory, branches, halt
    clear_prog();
    prog[0] = 7'h13; prog[1] = 7'h7C; prog[2] = 7'h11; prog[3] = 7'h34;
    prog[4] = 7'h75; prog[5] = 7'h29; prog[6] = 7'h5F; prog[7] = 7'h10;
    prog[8] = 7'h5A; prog[10] = 7'h6D;
    do_reset();
    run_cycles(4, "R4 dir");
    check("R4 sub wrap 1-3", acc_o, 14);
    check("R5 imm[3:2] ignored on store", ram_o[3:0], 3);
    run_cycles(2, "R4 dir");
    check("R4 add wrap 14+14", acc_o, 12);
    check("R5 store word1", ram_o[7:4], 14);
    run_cycles(1, "R6 dir");
    check("R6 JZ not taken", pc_o, 7);
    run_cycles(2, "R6 dir");
    check("R6 JZ taken", pc_o, 10);
    run_cycles(1, "R5 dir");
    check("R5 LDA word1 via imm 0xD", acc_o, 14);
    run_cycles(1, "R7 dir");
    check("R7 halted", halted_o, 1);
    check("R7 pc at halt word", pc_o, 11);
    for (int i = 0; i < 16; i++) prog[i] = 7'(($urandom % 7) + 1) << 4 | 7'($urandom % 16);
    run_cycles(5, "R7 frozen");
    check("R7 acc frozen", acc_o, 14);

    // R9: Fibonacci
    clear_prog();
    prog[0] = 7'h11; prog[1] = 7'h70; prog[2] = 7'h71; prog[3] = 7'h60;
    prog[4] = 7'h21; prog[5] = 7'h5C; prog[6] = 7'h72; prog[7] = 7'h61;
    prog[8] = 7'h70; prog[9] = 7'h62; prog[10] = 7'h71; prog[11] = 7'h43;
    exp_pairs = '{8'h11, 8'h12, 8'h23, 8'h35, 8'h58,
                  8'h8D, 8'hD5, 8'h52, 8'h27, 8'h79};
    pairs_seen = 0;
    do_reset();
    for (int c = 0; c < 200 && !m_halt; c++) begin
      run_cycles(1, "R9 fib");
      if (pc_o == 4'd3 && !halted_o) begin
        if (pairs_seen < 10)
          check("R9 pair", {ram_o[3:0], ram_o[7:4]}, exp_pairs[pairs_seen]);
        pairs_seen++;
      end
    end
    check("R9 lap count", pairs_seen, 10);
    check("R9 halted", halted_o, 1);
    check("R9 halt pc", pc_o, 12);

    // constrained random programs, lockstep against the model
    for (int r = 0; r < 24; r++) begin
      for (int i = 0; i < 16; i++) begin
        logic [2:0] op;
        op = (r % 2 == 0) ? 3'($urandom_range(1, 7)) : 3'($urandom % 8);
        prog[i] = {op, 4'($urandom % 16)};
      end
      do_reset();
      run_cycles(60, "R3-rand");
      if (m_halt) begin
        for (int i = 0; i < 16; i++) prog[i] = 7'($urandom);
        run_cycles(4, "R7 rand frozen");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule